// File: doc/BRIEF.md
# Converter power-state controller

This block decides whether a data converter is running, in a commanded sleep, or fully powered down. Two sources compete for that decision. A hardware start level has the final word: while it is low the converter is powered down and nothing on the serial side can change that. While start is high, sleep and wakeup commands move the converter between running and sleeping. The command decoder raises a strobe on the serial clock edge that completes the eighth bit of a byte and presents the opcode with it. A sleep command is not obeyed at once; the block waits for the conversion in progress to report completion.

Any change of the chip-select level, in either direction, cancels a sleep or a pending sleep and brings the converter back to the running state. Each return to running from a stopped state emits a one-cycle restart pulse for the conversion sequencer. A permit output tells the command decoder, combinationally for the opcode now presented, whether that command may be executed in the present power state. While running every opcode is permitted. While stopped only a short list is permitted.

Top module: `pwrctl_top`

## Requirements
- R1: When `start_i` is low at a clock edge, the state after that edge is power-down: `analog_en_o` = 0 and `awake_o` = 0. This holds whatever the previous state was and whatever command or chip-select activity occurs in the same cycle.
- R2: A wakeup strobe (`cmd_vld_i` = 1, `cmd_op_i` = 8'h00) sampled while `start_i` is low has no effect. `awake_o` stays 0, `analog_en_o` stays 0, and no restart pulse is produced.
- R3: A sleep strobe (`cmd_op_i` = 8'h02) sampled while running, with `start_i` high and no chip-select change, enters a pending-sleep state. In that state `awake_o` and `analog_en_o` both stay 1 until a conversion-done pulse is seen.
- R4: A `conv_done_i` pulse sampled during pending sleep, with no wakeup strobe and no chip-select change in the same cycle, enters sleep. In sleep `awake_o` = 0 and `analog_en_o` = 1.
- R5: A wakeup strobe sampled with `start_i` high makes `awake_o` 1 from the clock edge that samples the strobe. This applies from sleep and from pending sleep, so the strobe also cancels a pending sleep.
- R6: A change of `cs_n_i` level between two consecutive clock edges, with `start_i` high, returns the block to running at the second of those edges. The change may be a rise or a fall, and it also cancels a pending sleep.
- R7: While `awake_o` = 0, `cmd_permit_o` is 1 only for these opcodes: 8'h00 (wakeup), 8'h12 (read result), 8'h14 (start continuous read), 8'h16 (stop continuous read) and 8'hFF (no-op). For every other opcode it is 0. While `awake_o` = 1, `cmd_permit_o` is 1 for every opcode.
- R8: `conv_restart_o` is a single-cycle pulse, coincident with the first cycle of running, whenever the block enters running from sleep or from power-down. This includes the first edge after `start_i` rises. It is never raised in any other case.
- R9: The reset `rst_n` is synchronous and active low. An edge with `rst_n` low sets power-down if `start_i` is low and running otherwise, clears `conv_restart_o`, and records the present `cs_n_i` level as the reference for R6.
- R10: Priority at one edge, from highest to lowest: start low (R1); leaving power-down when start is high; chip-select change or wakeup (R5, R6); sleep strobe (R3); conversion done (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-domain clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Hardware start level; low forces power-down |
| cs_n_i | input | 1 | Chip-select level; any change wakes the block |
| cmd_vld_i | input | 1 | Decoded-command strobe, high in the eighth-bit cycle |
| cmd_op_i | input | 8 | Opcode presented with the strobe and to the permit logic |
| conv_done_i | input | 1 | One-cycle pulse at the end of a conversion |
| analog_en_o | output | 1 | Analog section enable, low only in power-down |
| awake_o | output | 1 | High while running or while a sleep is pending |
| conv_restart_o | output | 1 | One-cycle pulse on return to running from a stopped state |
| cmd_permit_o | output | 1 | High when the presented opcode may execute in this state |

## Verification
The bench builds the block with its default opcode parameters: 8-bit opcodes, wakeup 00h, sleep 02h, and the five-entry stopped-state list. With these values every permitted and masked code, and every pairing of a chip-select change with a command or a conversion-done pulse, can be reached directly. Directed sequences cover the deferred sleep, its cancellation by both wake sources, and the priority of the start level over them. A long random phase then biases start high, so that the states that sit behind it are visited often.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_DRAIN = 2'd1,
      PS_NAP   = 2'd2,
      PS_OFF   = 2'd3
   } pwr_state_t;

   function automatic logic is_stopped(input pwr_state_t s);
      return (s == PS_NAP) || (s == PS_OFF);
   endfunction

   function automatic logic is_running(input pwr_state_t s);
      return (s == PS_RUN) || (s == PS_DRAIN);
   endfunction

endpackage

// File: rtl/pwrctl_chg.sv
module pwrctl_chg #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic [W-1:0] lvl_i,
   output logic         chg_o
);
   logic [W-1:0] prev_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("pwrctl_chg: W must be at least 1");
      end
   endgenerate

   // The level is captured on every edge, including reset edges, so the
   // reference after reset is the level present during reset.
   always_ff @(posedge clk) begin
      prev_q <= lvl_i;
   end

   assign chg_o = |(lvl_i ^ prev_q);
endmodule

// File: rtl/pwrctl_gate.sv
module pwrctl_gate #(
   parameter int unsigned OP_W   = 8,
   parameter int unsigned N_KEEP = 5,
   parameter logic [N_KEEP*OP_W-1:0] KEEP_OPS = '0
) (
   input  logic [OP_W-1:0] op_i,
   input  logic            stopped_i,
   output logic            permit_o
);
   logic [N_KEEP-1:0] hit;

   generate
      if (N_KEEP < 1) begin : g_bad_n
         $error("pwrctl_gate: N_KEEP must be at least 1");
      end
      for (genvar k = 0; k < N_KEEP; k++) begin : g_match
         assign hit[k] = (op_i == KEEP_OPS[k*OP_W +: OP_W]);
      end
   endgenerate

   assign permit_o = !stopped_i || (|hit);
endmodule

// File: rtl/pwrctl_fsm.sv
module pwrctl_fsm
   import pwrctl_pkg::*;
#(
   parameter int unsigned     OP_W     = 8,
   parameter logic [OP_W-1:0] OP_WAKE  = 8'h00,
   parameter logic [OP_W-1:0] OP_SLEEP = 8'h02
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            cs_chg_i,
   input  logic            cmd_vld_i,
   input  logic [OP_W-1:0] cmd_op_i,
   input  logic            conv_done_i,
   output pwr_state_t      state_o,
   output logic            restart_o
);
   pwr_state_t state_q, state_d;
   logic       restart_q;
   logic       wake_cmd, sleep_cmd;

   assign wake_cmd  = cmd_vld_i && (cmd_op_i == OP_WAKE);
   assign sleep_cmd = cmd_vld_i && (cmd_op_i == OP_SLEEP);

   // Priority ladder: pin, leaving power-down, wake sources, sleep, done.
   always_comb begin
      state_d = state_q;
      if (!start_i)                          state_d = PS_OFF;
      else if (state_q == PS_OFF)            state_d = PS_RUN;
      else if (cs_chg_i || wake_cmd)         state_d = PS_RUN;
      else if (state_q == PS_RUN && sleep_cmd)
                                             state_d = PS_DRAIN;
      else if (state_q == PS_DRAIN && conv_done_i)
                                             state_d = PS_NAP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= start_i ? PS_RUN : PS_OFF;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         restart_q <= (state_d == PS_RUN) && is_stopped(state_q);
      end
   end

   assign state_o   = state_q;
   assign restart_o = restart_q;

   a_r1_pin_forces_off : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> state_q == PS_OFF);

   a_r2_wake_ignored_off : assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && wake_cmd) |=> (state_q == PS_OFF && !restart_o));

   a_r3_sleep_deferred : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == PS_RUN && sleep_cmd && !cs_chg_i) |=> state_q == PS_DRAIN);

   a_r4_done_enters_nap : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == PS_DRAIN && conv_done_i && !wake_cmd && !cs_chg_i)
      |=> state_q == PS_NAP);

   a_r5_wake_immediate : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && wake_cmd) |=> state_q == PS_RUN);

   a_r6_cs_change_wakes : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && cs_chg_i) |=> state_q == PS_RUN);

   a_r8_restart_single : assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |=> !restart_o);

   a_r8_restart_only_running : assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> state_q == PS_RUN);
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
   import pwrctl_pkg::*;
#(
   parameter int unsigned     OP_W     = 8,
   parameter logic [OP_W-1:0] OP_WAKE  = 8'h00,
   parameter logic [OP_W-1:0] OP_SLEEP = 8'h02,
   parameter logic [OP_W-1:0] OP_RDATA = 8'h12,
   parameter logic [OP_W-1:0] OP_RDC   = 8'h14,
   parameter logic [OP_W-1:0] OP_SDC   = 8'h16,
   parameter logic [OP_W-1:0] OP_NOP   = 8'hFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            cs_n_i,
   input  logic            cmd_vld_i,
   input  logic [OP_W-1:0] cmd_op_i,
   input  logic            conv_done_i,
   output logic            analog_en_o,
   output logic            awake_o,
   output logic            conv_restart_o,
   output logic            cmd_permit_o
);
   localparam int unsigned N_KEEP = 5;
   localparam logic [N_KEEP*OP_W-1:0] KEEP_OPS =
      {OP_NOP, OP_SDC, OP_RDC, OP_RDATA, OP_WAKE};

   generate
      if (OP_W < 2) begin : g_bad_opw
         $error("pwrctl_top: OP_W must be at least 2");
      end
      if (OP_WAKE == OP_SLEEP) begin : g_bad_ops
         $error("pwrctl_top: wake and sleep opcodes must differ");
      end
   endgenerate

   pwr_state_t state;
   logic       cs_chg;
   logic       stopped;

   pwrctl_chg #(.W(1)) u_cs (
      .clk   (clk),
      .lvl_i (cs_n_i),
      .chg_o (cs_chg)
   );

   pwrctl_fsm #(
      .OP_W     (OP_W),
      .OP_WAKE  (OP_WAKE),
      .OP_SLEEP (OP_SLEEP)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .cs_chg_i    (cs_chg),
      .cmd_vld_i   (cmd_vld_i),
      .cmd_op_i    (cmd_op_i),
      .conv_done_i (conv_done_i),
      .state_o     (state),
      .restart_o   (conv_restart_o)
   );

   assign stopped     = is_stopped(state);
   assign awake_o     = is_running(state);
   assign analog_en_o = (state != PS_OFF);

   pwrctl_gate #(
      .OP_W     (OP_W),
      .N_KEEP   (N_KEEP),
      .KEEP_OPS (KEEP_OPS)
   ) u_gate (
      .op_i      (cmd_op_i),
      .stopped_i (stopped),
      .permit_o  (cmd_permit_o)
   );

   a_r7_sleep_masked_stopped : assert property (@(posedge clk) disable iff (!rst_n)
      (!awake_o && cmd_op_i == OP_SLEEP) |-> !cmd_permit_o);

   a_r7_all_open_running : assert property (@(posedge clk) disable iff (!rst_n)
      awake_o |-> cmd_permit_o);

   a_r7_wake_always_open : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_i == OP_WAKE) |-> cmd_permit_o);

   a_r1_off_no_analog : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!analog_en_o && !awake_o));
endmodule

// File: tb/sim_pwrctl_top.sv
`timescale 1ns/1ps
module sim_pwrctl_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cs_n_i = 1'b1;
   logic       cmd_vld_i = 1'b0;
   logic [7:0] cmd_op_i = 8'hFF;
   logic       conv_done_i = 1'b0;
   logic       analog_en_o, awake_o, conv_restart_o, cmd_permit_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   pwrctl_top u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .cs_n_i         (cs_n_i),
      .cmd_vld_i      (cmd_vld_i),
      .cmd_op_i       (cmd_op_i),
      .conv_done_i    (conv_done_i),
      .analog_en_o    (analog_en_o),
      .awake_o        (awake_o),
      .conv_restart_o (conv_restart_o),
      .cmd_permit_o   (cmd_permit_o)
   );

   // Reference model: 0 running, 1 draining, 2 napping, 3 off.
   int m_st = 3;
   bit m_rst_pulse = 0;
   bit m_cs_ref = 1;
   bit m_valid = 0;

   always @(posedge clk) begin
      int nxt;
      bit chg, wk, sl;
      if (!rst_n) begin
         m_st = start_i ? 0 : 3;
         m_rst_pulse = 0;
         m_valid = 1;
      end else begin
         chg = (cs_n_i != m_cs_ref);
         wk  = cmd_vld_i && cmd_op_i == 8'h00;
         sl  = cmd_vld_i && cmd_op_i == 8'h02;
         nxt = m_st;
         if (!start_i)                      nxt = 3;
         else if (m_st == 3)                nxt = 0;
         else if (chg || wk)                nxt = 0;
         else if (m_st == 0 && sl)          nxt = 1;
         else if (m_st == 1 && conv_done_i) nxt = 2;
         m_rst_pulse = (nxt == 0) && (m_st >= 2);
         m_st = nxt;
      end
      m_cs_ref = cs_n_i;
   end

   function automatic bit exp_permit(int st, logic [7:0] op);
      if (st < 2) return 1;
      return op == 8'h00 || op == 8'h12 || op == 8'h14 || op == 8'h16 || op == 8'hFF;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   // Per-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n && m_valid && !done_flag) begin
         chk("R1 R2 R3 R4 R5 R6 awake_o", awake_o, m_st < 2);
         chk("R1 R4 analog_en_o", analog_en_o, m_st != 3);
         chk("R8 conv_restart_o", conv_restart_o, m_rst_pulse);
         chk("R7 cmd_permit_o", cmd_permit_o, exp_permit(m_st, cmd_op_i));
      end
   end

   task automatic go();
      @(negedge clk); #2;
      cmd_vld_i = 1'b0;
      conv_done_i = 1'b0;
   endtask

   task automatic send(logic [7:0] op);
      cmd_vld_i = 1'b1;
      cmd_op_i = op;
      go();
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // R9: reset with start low gives power-down.
      go(); go();
      rst_n = 1'b1;
      go();
      chk("R9 off after reset awake", awake_o, 1'b0);
      chk("R9 off after reset analog", analog_en_o, 1'b0);
      chk("R9 no restart after reset", conv_restart_o, 1'b0);

      // R2: wakeup while start low ignored.
      send(8'h00);
      chk("R2 wake ignored awake", awake_o, 1'b0);
      chk("R2 wake ignored restart", conv_restart_o, 1'b0);

      // R7: masking while stopped.
      cmd_op_i = 8'h02; #1;
      chk("R7 sleep masked", cmd_permit_o, 1'b0);
      cmd_op_i = 8'h14; #1;
      chk("R7 start-continuous open", cmd_permit_o, 1'b1);
      cmd_op_i = 8'h40; #1;
      chk("R7 other masked", cmd_permit_o, 1'b0);
      cmd_op_i = 8'hFF;

      // R8: start rising leaves power-down with a restart pulse.
      start_i = 1'b1;
      go();
      chk("R8 start rise awake", awake_o, 1'b1);
      chk("R8 start rise pulse", conv_restart_o, 1'b1);
      go();
      chk("R8 pulse single", conv_restart_o, 1'b0);

      // R3: deferred sleep.
      send(8'h02);
      chk("R3 still awake while pending", awake_o, 1'b1);
      go(); go();
      chk("R3 pending holds", awake_o, 1'b1);
      // R4: conversion done enters sleep.
      conv_done_i = 1'b1;
      go();
      chk("R4 asleep awake", awake_o, 1'b0);
      chk("R4 asleep analog", analog_en_o, 1'b1);
      // R5: wake from sleep.
      send(8'h00);
      chk("R5 wake awake", awake_o, 1'b1);
      chk("R5 wake restart", conv_restart_o, 1'b1);

      // R6: cs change from sleep.
      send(8'h02);
      conv_done_i = 1'b1; go();
      chk("R6 asleep before cs", awake_o, 1'b0);
      cs_n_i = 1'b0; go();
      chk("R6 cs fall wakes", awake_o, 1'b1);
      chk("R6 cs fall restart", conv_restart_o, 1'b1);

      // R5 and R6 cancel pending sleep.
      send(8'h02);
      send(8'h00);
      conv_done_i = 1'b1; go();
      chk("R5 pending cancelled", awake_o, 1'b1);
      send(8'h02);
      cs_n_i = 1'b1; go();
      conv_done_i = 1'b1; go();
      chk("R6 pending cancelled by cs rise", awake_o, 1'b1);

      // R10: cs change beats sleep strobe in the same cycle.
      cs_n_i = 1'b0; cmd_vld_i = 1'b1; cmd_op_i = 8'h02; go();
      conv_done_i = 1'b1; go();
      chk("R10 cs over sleep", awake_o, 1'b1);

      // R1: start low overrides pending and sleep.
      send(8'h02);
      start_i = 1'b0; cs_n_i = 1'b1; cmd_vld_i = 1'b1; cmd_op_i = 8'h00; go();
      chk("R1 start low off", analog_en_o, 1'b0);
      chk("R1 start low awake", awake_o, 1'b0);

      // R9: reset with start high gives running.
      start_i = 1'b1; rst_n = 1'b0; go(); rst_n = 1'b1; go();
      chk("R9 awake after reset", awake_o, 1'b1);
      chk("R9 no pulse after reset", conv_restart_o, 1'b0);

      // Random phase.
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         start_i = (r < 93);
         if ($urandom_range(0, 9) == 0) cs_n_i = ~cs_n_i;
         cmd_vld_i = ($urandom_range(0, 9) < 3);
         case ($urandom_range(0, 5))
            0: cmd_op_i = 8'h00;
            1, 2: cmd_op_i = 8'h02;
            3: cmd_op_i = 8'h12;
            4: cmd_op_i = 8'hFF;
            default: cmd_op_i = 8'($urandom);
         endcase
         conv_done_i = ($urandom_range(0, 5) == 0);
         if (i % 997 == 500) rst_n = 1'b0;
         else rst_n = 1'b1;
         @(negedge clk); #2;
      end
      rst_n = 1'b1;
      go(); go();
      finish_run();
   end
endmodule